// File: doc/BRIEF.md
# Serial Memory Slave with Hold Pause

This block is the digital front end of a byte-wide serial memory that answers as an SPI mode-0 slave. A host selects it with an active-low select, clocks bits in on `si` and reads bits back on `so`. The block decodes a one-byte command and gathers a two-byte address. It then streams data bytes into or out of an on-block register array, moving the address forward by one after each byte. The block samples the serial pins with its own system clock, so `sck`, `cs_n`, `si`, `hold_n` and `wp_n` must already be synchronous to `clk` and slow compared with it.

The host can freeze a transfer at any bit by pulling `hold_n` low while `sck` is low. During the pause the serial clock and the select are disregarded and the output is released. When `hold_n` returns high, the transfer carries on from the same bit. A status byte holds a write-enable latch and a two-bit array protection level. The write-protect pin guards only that status byte, never the array directly. The output is half-duplex. `so_oe` is the tri-state enable for the pad and is raised only while read data or status is being shifted out.

Top module: `spi_mem_slave`

## Requirements
- R1: While `cs_n` is high (and no pause is active), `so_oe` is low and `sck`/`si` activity changes no state; the status byte read afterwards is unchanged.
- R2: A command is taken only from the first 8 bits after `cs_n` goes high then low; further bits after a complete one-byte command (0x06, 0x04) are ignored until `cs_n` rises.
- R3: `si` is taken on each rising `sck` edge, MSB first; `so` changes only after falling `sck` edges, MSB first, and each read byte appears whole on the rising edges that follow.
- R4: With `hold_n` low, `sck` edges and `cs_n` are ignored and the bit position, address and phase are kept; after `hold_n` returns high the transfer resumes at the same bit.
- R5: `so_oe` is low whenever the pause is active.
- R6: `hold_n` is sampled only while `sck` is low; a change of `hold_n` while `sck` is high raises a one-cycle `hold_err` pulse per clock and leaves the sampled value unchanged.
- R7: Commands: 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read, 0x02 write. Status byte: bit 1 write-enable latch, bits 3:2 protection level, all other bits read 0; it repeats for as long as it is clocked.
- R8: 0x04 clears the latch at once; the latch is cleared when `cs_n` rises after any 0x02 or 0x01 command; array and status writes are dropped while the latch is clear.
- R9: With `wp_n` low when the status data byte completes, the status write is dropped.
- R10: Protection level 1 blocks writes to the top quarter of the array, level 2 the top half, level 3 the whole array, level 0 nothing; blocked bytes leave the array unchanged while the burst continues.
- R11: The address is sent as two bytes, MSB first; only the low `ADDR_W` bits are kept; the address steps by one after each data byte and wraps from all ones to zero.
- R12: `so_oe` stays low while a command, address or write data byte is being shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low guard on status writes |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad |
| hold_err | output | 1 | Pulse: `hold_n` moved while `sck` was high |

## Verification
The bench builds the block with `ADDR_W` = 8, which gives a 256-byte array. With that size a two-byte burst from 0xFF reaches the wrap to 0x00, and the quarter and half protection boundaries at 0xC0 and 0x80 can be probed with single-byte writes on either side. Because the first address byte is then wholly outside the kept width, it is sent as 0xFF to show that extra high address bits are discarded. The pause test stops a read in the middle of a byte, toggles `sck` and `cs_n` during the pause and then confirms that the byte still arrives intact.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,   // ignore bits until select is released
        ST_OPC,    // collecting the command byte
        ST_ADDR,   // collecting the two address bytes
        ST_WR,     // array write data
        ST_RD,     // array read data
        ST_SRRD,   // status read data
        ST_SRWR    // status write data
    } phase_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    localparam int ADDR_FIELD_W = 16;

endpackage

// File: rtl/spi_mem_edge.sv
module spi_mem_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic hold_n,
    output logic rise,
    output logic fall,
    output logic paused,
    output logic hold_err
);
    typedef struct packed {
        logic sck_prev;
        logic hold_s;
        logic err;
    } edge_t;

    edge_t d, q;

    always_comb begin
        d          = q;
        d.sck_prev = sck;
        d.err      = 1'b0;
        if (!sck) begin
            d.hold_s = hold_n;
        end else if (hold_n != q.hold_s) begin
            d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sck_prev: 1'b0, hold_s: 1'b1, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rise     = sck & ~q.sck_prev & q.hold_s;
    assign fall     = ~sck & q.sck_prev & q.hold_s;
    assign paused   = ~q.hold_s;
    assign hold_err = q.err;

    // a flagged violation never moves the sampled pause level
    p_hold_sample_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> $stable(q.hold_s));

endmodule

// File: rtl/spi_mem_prot.sv
module spi_mem_prot #(
    parameter int AW = 11
) (
    input  logic [1:0]    level,
    input  logic [AW-1:0] addr,
    output logic          locked
);
    always_comb begin
        unique case (level)
            2'd0:    locked = 1'b0;
            2'd1:    locked = &addr[AW-1:AW-2];
            2'd2:    locked = addr[AW-1];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe,
    output logic hold_err
);
    localparam int AW = ADDR_W;
    localparam int SW = ADDR_FIELD_W;

    typedef struct packed {
        phase_e        state;
        logic [3:0]    cnt;
        logic [SW-1:0] sh;
        logic [AW-1:0] addr;
        logic [7:0]    obyte;
        logic          so;
        logic          drive;
        logic          wel;
        logic [1:0]    bp;
        logic          clr_wel;
        logic          wr_cmd;
    } core_t;

    core_t d, q;

    logic          rise, fall, paused;
    logic          locked;
    logic          mem_we;
    logic [AW-1:0] mem_wa, raddr, addr_inc;
    logic [7:0]    mem_wd, rdata, status_byte;
    logic [SW-1:0] sh_in;

    spi_mem_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .hold_n   (hold_n),
        .rise     (rise),
        .fall     (fall),
        .paused   (paused),
        .hold_err (hold_err)
    );

    spi_mem_prot #(.AW(AW)) u_prot (
        .level  (q.bp),
        .addr   (q.addr),
        .locked (locked)
    );

    spi_mem_array #(.AW(AW), .DW(8)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_wa),
        .wdata (mem_wd),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign sh_in       = {q.sh[SW-2:0], si};
    assign addr_inc    = q.addr + 1'b1;
    assign raddr       = (q.state == ST_ADDR) ? sh_in[AW-1:0] : addr_inc;
    assign status_byte = {4'b0000, q.bp, q.wel, 1'b0};

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        mem_wa = q.addr;
        mem_wd = sh_in[7:0];
        if (!paused && cs_n) begin
            // select released: re-arm for the next command
            d.state   = ST_OPC;
            d.cnt     = '0;
            d.drive   = 1'b0;
            d.clr_wel = 1'b0;
            if (q.clr_wel) d.wel = 1'b0;
        end else if (!paused && rise) begin
            d.sh  = sh_in;
            d.cnt = q.cnt + 4'd1;
            unique case (q.state)
                ST_OPC: if (q.cnt == 4'd7) begin
                    d.cnt = '0;
                    unique case (sh_in[7:0])
                        OP_WREN:  begin d.wel = 1'b1; d.state = ST_WAIT; end
                        OP_WRDI:  begin d.wel = 1'b0; d.state = ST_WAIT; end
                        OP_RDSR:  begin d.obyte = status_byte; d.state = ST_SRRD; end
                        OP_WRSR:  begin d.clr_wel = 1'b1; d.state = ST_SRWR; end
                        OP_READ:  begin d.wr_cmd = 1'b0; d.state = ST_ADDR; end
                        OP_WRITE: begin d.wr_cmd = 1'b1; d.clr_wel = 1'b1; d.state = ST_ADDR; end
                        default:  d.state = ST_WAIT;
                    endcase
                end
                ST_ADDR: if (q.cnt == 4'd15) begin
                    d.cnt  = '0;
                    d.addr = sh_in[AW-1:0];
                    if (q.wr_cmd) begin
                        d.state = ST_WR;
                    end else begin
                        d.state = ST_RD;
                        d.obyte = rdata;
                    end
                end
                ST_WR: if (q.cnt == 4'd7) begin
                    d.cnt  = '0;
                    d.addr = addr_inc;
                    mem_we = q.wel & ~locked;
                end
                ST_RD: if (q.cnt == 4'd7) begin
                    d.cnt   = '0;
                    d.addr  = addr_inc;
                    d.obyte = rdata;
                end
                ST_SRRD: if (q.cnt == 4'd7) begin
                    d.cnt   = '0;
                    d.obyte = status_byte;
                end
                ST_SRWR: if (q.cnt == 4'd7) begin
                    d.cnt   = '0;
                    d.state = ST_WAIT;
                    if (q.wel && wp_n) d.bp = sh_in[3:2];
                end
                default: d.cnt = q.cnt;
            endcase
        end else if (!paused && fall && (q.state == ST_RD || q.state == ST_SRRD)) begin
            d.so    = q.obyte[3'd7 - q.cnt[2:0]];
            d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign so    = q.so;
    assign so_oe = q.drive & ~paused & ~cs_n;

    // the transfer position is frozen for every cycle after a paused one
    p_paused_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(paused) |-> ($stable(q.cnt) && $stable(q.state) && $stable(q.addr)));

    // nothing is driven while bits are flowing into the block
    p_quiet_inbound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state inside {ST_OPC, ST_ADDR, ST_WR, ST_SRWR}) |-> !so_oe);

    // serial output only moves after a falling serial clock edge
    p_so_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.so != $past(q.so)) |-> !$past(sck));

    // read bursts step the address by exactly one, wrapping at the top
    p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RD && $past(q.state) == ST_RD && q.addr != $past(q.addr))
        |-> (q.addr == AW'($past(q.addr) + 1'b1)));

    // protection level only changes with the pin high and the latch set
    p_status_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.bp != $past(q.bp)) |-> ($past(wp_n) && $past(q.wel)));

    // ending a write-type command leaves the latch clear
    p_wel_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.clr_wel) && !q.clr_wel) |-> !q.wel);

endmodule

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
    localparam int AW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe, hold_err;

    always #5 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe), .hold_err(hold_err)
    );

    int nchk = 0, nfail = 0, err_cnt = 0, mcnt = 0;
    bit done = 1'b0, quiet = 1'b0;
    logic [7:0] mbyte = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        si = b; wclk(3); sck = 1'b1; wclk(4); sck = 1'b0; wclk(1);
    endtask

    task automatic tx(input logic [7:0] b);
        quiet = 1'b1;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        quiet = 1'b0;
    endtask

    task automatic rx(input logic [7:0] e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        for (int i = 0; i < 8; i++) bit_out(1'b0);
    endtask

    task automatic sel;   cs_n = 1'b0; wclk(2); endtask
    task automatic desel; wclk(2); cs_n = 1'b1; wclk(3); endtask

    task automatic rdsr(input logic [7:0] e, input string req);
        sel; tx(8'h05); rx(e, req); desel;
    endtask
    task automatic wren; sel; tx(8'h06); desel; endtask
    task automatic wr1(input logic [7:0] a, input logic [7:0] v);
        sel; tx(8'h02); tx(8'h00); tx(a); tx(v); desel;
    endtask
    task automatic rd1(input logic [7:0] a, input logic [7:0] e, input string req);
        sel; tx(8'h03); tx(8'hFF); tx(a); rx(e, req); desel;
    endtask
    task automatic wrsr(input logic [7:0] v);
        wren; sel; tx(8'h01); tx(v); desel;
    endtask

    // scoreboard monitor: gathers bytes on rising sck and pops expectations
    always @(posedge sck) begin
        if (quiet) begin
            check(!so_oe, "R12", so_oe, 0);
        end else if (so_oe) begin
            mbyte = {mbyte[6:0], so};
            mcnt++;
            if (mcnt == 8) begin
                mcnt = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected byte", mbyte, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(mbyte == e, t, mbyte, e);
                end
            end
        end
    end

    always @(posedge clk) if (hold_err) err_cnt++;

    task automatic finish_run;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        wclk(150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=0 expected=1");
            finish_run;
        end
    end

    initial begin
        int e0;
        wclk(5); rst_n = 1'b1; wclk(2);
        check(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
        check(hold_err == 1'b0, "R6 reset err", hold_err, 0);

        rdsr(8'h00, "R7 status after reset");

        // write without the latch is dropped
        wr1(8'h10, 8'hA5);
        rd1(8'h10, 8'h00, "R8 write without latch");

        wren;
        rdsr(8'h02, "R7 latch bit");
        rdsr(8'h02, "R8 latch kept over status read");

        // burst write, latch clears at select release
        sel; tx(8'h02); tx(8'h00); tx(8'h10); tx(8'h11); tx(8'h22); tx(8'h33); desel;
        rdsr(8'h00, "R8 latch cleared after write");
        sel; tx(8'h03); tx(8'hFF); tx(8'h10);
        rx(8'h11, "R11 burst b0"); rx(8'h22, "R3 burst b1"); rx(8'h33, "R11 burst b2");
        desel;

        // address wrap
        wren;
        sel; tx(8'h02); tx(8'h00); tx(8'hFF); tx(8'h44); tx(8'h55); desel;
        sel; tx(8'h03); tx(8'h00); tx(8'hFF);
        rx(8'h44, "R11 top byte"); rx(8'h55, "R11 wrapped byte"); desel;
        rd1(8'h00, 8'h55, "R11 wrap landed at zero");

        // select high: clocking is ignored
        cs_n = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_out(OP_BIT(i));
            check(so_oe == 1'b0, "R1 oe while deselected", so_oe, 0);
        end
        rdsr(8'h00, "R1 no command while deselected");

        // trailing bits after a one-byte command are ignored
        sel; tx(8'h06); tx(8'h04); desel;
        rdsr(8'h02, "R2 second command ignored");
        sel; tx(8'h04); desel;
        rdsr(8'h00, "R8 clear latch command");

        // status guard by pin
        wp_n = 1'b0; wrsr(8'h0C); wp_n = 1'b1;
        rdsr(8'h00, "R9 status write blocked by pin");
        wrsr(8'h04);
        rdsr(8'h04, "R7 protection level 1");

        // quarter protection
        wren; wr1(8'hC0, 8'h77);
        rd1(8'hC0, 8'h00, "R10 quarter blocks 0xC0");
        wren; wr1(8'hBF, 8'h66);
        rd1(8'hBF, 8'h66, "R10 quarter allows 0xBF");
        // half protection
        wrsr(8'h08);
        wren; wr1(8'h80, 8'h99);
        rd1(8'h80, 8'h00, "R10 half blocks 0x80");
        wren; wr1(8'h7F, 8'h12);
        rd1(8'h7F, 8'h12, "R10 half allows 0x7F");
        // full protection
        wrsr(8'h0C);
        rdsr(8'h0C, "R10 level 3 set");
        wren; wr1(8'h05, 8'h5A);
        rd1(8'h05, 8'h00, "R10 full blocks");

        // pause in the middle of a read byte
        e0 = err_cnt;
        sel; tx(8'h03); tx(8'h00); tx(8'h10);
        exp_q.push_back(8'h11); tag_q.push_back("R4 byte across pause");
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        hold_n = 1'b0; wclk(3);
        check(so_oe == 1'b0, "R5 oe during pause", so_oe, 0);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b1; wclk(3); sck = 1'b0; wclk(3);
        end
        cs_n = 1'b1; wclk(3); cs_n = 1'b0; wclk(3);
        hold_n = 1'b1; wclk(3);
        check(so_oe == 1'b1, "R4 drive resumes", so_oe, 1);
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        desel;
        check(err_cnt == e0, "R6 legal pause no error", err_cnt, e0);

        // illegal pause change with sck high
        sck = 1'b1; wclk(2); hold_n = 1'b0; wclk(3);
        check(err_cnt > e0, "R6 violation flagged", err_cnt, e0 + 1);
        sck = 1'b0; wclk(2); hold_n = 1'b1; wclk(3);

        check(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
        check(mcnt == 0, "R3 whole bytes", mcnt, 0);
        done = 1'b1;
        finish_run;
    end

    function automatic logic OP_BIT(input int i);
        logic [7:0] v;
        v = 8'h06;
        return v[i];
    endfunction

endmodule